// File: doc/BRIEF.md
# Hazard Stall Tracking Unit

This block sits at the head of a single-issue, in-order issue stage. Each cycle it looks at the hazard indications for the instruction waiting at the head and decides whether that instruction may issue. The indications are a read-after-write dependency (a cycle count or an unknown-length flag), a busy functional resource, a custom stall length, and the write-back latencies that the instruction will produce. When the instruction may not issue, the block records a single stall. The stall holds a remaining-cycle count and a kind code.

While a stall counts down, the block blocks issue and ignores the head inputs. When the count runs out, the block emits a replay pulse and checks the same head instruction again against the inputs present in that cycle. A separate write-back countdown remembers when the most recent in-order instruction will write its result. A younger instruction that would write earlier is held back for the difference, so results land in program order. An instruction flagged as allowed to retire out of order skips this ordering check.

The decision outputs are combinational from the current inputs and the registered stall state. Stall state and the write-back countdown change on the rising clock edge.

Top module: `hazard_stall_unit`

## Requirements
- R1: After reset no stall is recorded and the write-back countdown is zero. With no hazards, `issue_ok` follows `head_valid`, `stall_active` is 0, `stall_kind` is 0 and `replay` is 0.
- R2: When several hazards are present in the same evaluation, only the highest-priority one sets the stall. The order from highest to lowest is register dependency, busy resource, custom hazard, write-back ordering.
- R3: A register dependency (`raw_hit`=1) stalls for `raw_cycles` cycles. With `raw_unknown`=1 it stalls for exactly 1 cycle. If `raw_hit`=1, `raw_unknown`=0 and `raw_cycles`=0, there is no dependency stall.
- R4: A busy resource (`res_busy`=1) stalls for exactly 1 cycle.
- R5: A nonzero `cust_cycles` stalls for that many cycles. A value of 0 means no custom hazard.
- R6: The earliest write-back is the minimum of `instr_lat` and each valid destination latency, where a negative latency counts as 0. The ordering stall applies only when the countdown is nonzero, `ooo_retire`=0 and the earliest write-back is below the countdown. It then lasts countdown minus earliest.
- R7: An issue with `ooo_retire`=0 and `instr_lat`=L≥1 makes the countdown read L−1 in the next cycle. Otherwise a nonzero countdown drops by 1 each cycle. Issues with `ooo_retire`=1 or L=0 do not load it.
- R8: A stall of N cycles detected in cycle t blocks issue in cycles t..t+N−1, and the head inputs are ignored in cycles t+1..t+N−1. `replay`=1 in cycle t+N, and in that cycle the current inputs are checked again. A fresh hazard there starts a new stall and issue stays blocked.
- R9: `stall_kind` encodes 0 none, 1 register dependency, 2 resource (dispatch), 3 custom, 4 write-back ordering. The bits of `stall_evt` are [0] register-file stall, [1] register pressure, [2] dispatch-group stall, [3] resource pressure, [4] custom stall. Kind 1 raises bits 0 and 1, kind 2 raises bits 2 and 3, kind 3 raises bit 4, and kind 4 raises none.
- R10: `issue_ok`, `stall_active`, `stall_kind` and `stall_evt` describe the current cycle. A newly found hazard shows on them in the same cycle it is presented, and a held stall shows its recorded kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| head_valid | input | 1 | An instruction waits at the head |
| raw_hit | input | 1 | Read-after-write dependency present |
| raw_unknown | input | 1 | Dependency length unknown |
| raw_cycles | input | CW | Cycles left on the dependency |
| res_busy | input | 1 | A needed functional resource is busy |
| cust_cycles | input | CW | Custom hazard stall length, 0 for none |
| instr_lat | input | LW | Instruction latency |
| dest_lat | input | NDEST×(LW+1) | Signed per-destination write latencies |
| dest_vld | input | NDEST | Destination latency valid mask |
| ooo_retire | input | 1 | Instruction may write back out of order |
| issue_ok | output | 1 | Head instruction issues this cycle |
| stall_active | output | 1 | A stall is in force this cycle |
| stall_kind | output | 3 | Kind of the stall in force |
| replay | output | 1 | Stall expired, head is being checked again |
| stall_evt | output | 5 | Stall and pressure event flags |

## Verification
Every decision output is due in the same cycle as the inputs that cause it. The bench therefore drives at the falling edge and compares 1 ns later, before the next rising edge. Stall and countdown effects appear one rising edge later, and the bench predicts them in absolute cycle numbers. A stall found in cycle t releases at cycle t+N, and an issue at cycle t with latency L sets a write-back time of t+L, so the countdown in cycle c is t+L−c. Each cycle is modelled without exception, so the expected replay cycle and the ordering delay follow from subtraction alone, with no mirror of the internal counters.

// File: rtl/hsu_pkg.sv
package hsu_pkg;

  localparam int KIND_W = 3;
  localparam int EVT_W  = 5;

  typedef enum logic [KIND_W-1:0] {
    SK_NONE     = 3'd0,
    SK_REGDEP   = 3'd1,
    SK_DISPATCH = 3'd2,
    SK_CUSTOM   = 3'd3,
    SK_ORDER    = 3'd4
  } stall_kind_e;

  // Event flags raised for a stall kind that is in force.
  function automatic logic [EVT_W-1:0] evt_of(input logic [KIND_W-1:0] k);
    logic [EVT_W-1:0] e;
    e = '0;
    case (k)
      SK_REGDEP:   e = 5'b00011;
      SK_DISPATCH: e = 5'b01100;
      SK_CUSTOM:   e = 5'b10000;
      default:     e = '0;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/hsu_hazard_eval.sv
module hsu_hazard_eval
  import hsu_pkg::*;
#(
  parameter int CW    = 6,
  parameter int LW    = 6,
  parameter int NDEST = 2
) (
  input  logic                        raw_hit,
  input  logic                        raw_unknown,
  input  logic [CW-1:0]               raw_cycles,
  input  logic                        res_busy,
  input  logic [CW-1:0]               cust_cycles,
  input  logic [LW-1:0]               instr_lat,
  input  logic [NDEST-1:0][LW:0]      dest_lat,
  input  logic [NDEST-1:0]            dest_vld,
  input  logic                        ooo_retire,
  input  logic [LW-1:0]               wb_cnt,
  output logic                        haz_fire,
  output stall_kind_e                 haz_kind,
  output logic [CW-1:0]               haz_cycles,
  output logic [LW-1:0]               earliest
);

  logic raw_fire, cust_fire, order_fire;

  // Earliest write-back: min over latency and valid clamped destinations.
  always_comb begin
    earliest = instr_lat;
    for (int i = 0; i < NDEST; i++) begin
      if (dest_vld[i]) begin
        if (dest_lat[i][LW])
          earliest = '0;
        else if (dest_lat[i][LW-1:0] < earliest)
          earliest = dest_lat[i][LW-1:0];
      end
    end
  end

  assign raw_fire   = raw_hit && (raw_unknown || (raw_cycles != '0));
  assign cust_fire  = (cust_cycles != '0);
  assign order_fire = (wb_cnt != '0) && !ooo_retire && (earliest < wb_cnt);

  // Fixed priority: dependency, resource, custom, ordering.
  always_comb begin
    haz_fire   = 1'b1;
    haz_kind   = SK_NONE;
    haz_cycles = '0;
    if (raw_fire) begin
      haz_kind   = SK_REGDEP;
      haz_cycles = raw_unknown ? CW'(1) : raw_cycles;
    end else if (res_busy) begin
      haz_kind   = SK_DISPATCH;
      haz_cycles = CW'(1);
    end else if (cust_fire) begin
      haz_kind   = SK_CUSTOM;
      haz_cycles = cust_cycles;
    end else if (order_fire) begin
      haz_kind   = SK_ORDER;
      haz_cycles = CW'(wb_cnt - earliest);
    end else begin
      haz_fire   = 1'b0;
    end
  end

  always_comb begin
    if (haz_fire) assert (haz_cycles != '0) else $error("AST_STALL_NONZERO");  // R8
  end

endmodule

// File: rtl/hsu_stall_track.sv
module hsu_stall_track
  import hsu_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          head_valid,
  input  logic          haz_fire,
  input  stall_kind_e   haz_kind,
  input  logic [CW-1:0] haz_cycles,
  output logic          hold,
  output logic          replay,
  output logic          evaluate,
  output stall_kind_e   kind_q
);

  logic          vld_q;
  logic [CW-1:0] cnt_q;

  assign hold     = vld_q && (cnt_q != '0);
  assign replay   = vld_q && (cnt_q == '0);
  assign evaluate = head_valid && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      cnt_q  <= '0;
      kind_q <= SK_NONE;
    end else if (evaluate && haz_fire) begin
      vld_q  <= 1'b1;
      cnt_q  <= haz_cycles - CW'(1);
      kind_q <= haz_kind;
    end else if (hold) begin
      cnt_q  <= cnt_q - CW'(1);
    end else begin
      vld_q  <= 1'b0;
      cnt_q  <= '0;
      kind_q <= SK_NONE;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (vld_q && cnt_q == $past(cnt_q) - CW'(1))) else $error("AST_CNT_STEP");  // R8
  AST_KIND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (kind_q == $past(kind_q))) else $error("AST_KIND_KEPT");  // R10

endmodule

// File: rtl/hsu_wb_order.sv
module hsu_wb_order #(
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic          ooo_retire,
  input  logic [LW-1:0] instr_lat,
  output logic [LW-1:0] wb_cnt
);

  logic load;

  assign load = issue && !ooo_retire && (instr_lat != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wb_cnt <= '0;
    else if (load)
      wb_cnt <= instr_lat - LW'(1);
    else if (wb_cnt != '0)
      wb_cnt <= wb_cnt - LW'(1);
  end

  AST_WB_DECR: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && wb_cnt != '0) |=> (wb_cnt == $past(wb_cnt) - LW'(1))) else $error("AST_WB_DECR");  // R7
  AST_WB_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (wb_cnt == $past(instr_lat) - LW'(1))) else $error("AST_WB_LOAD");  // R7

endmodule

// File: rtl/hazard_stall_unit.sv
module hazard_stall_unit
  import hsu_pkg::*;
#(
  parameter int CW    = 6,
  parameter int LW    = 6,
  parameter int NDEST = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   head_valid,
  input  logic                   raw_hit,
  input  logic                   raw_unknown,
  input  logic [CW-1:0]          raw_cycles,
  input  logic                   res_busy,
  input  logic [CW-1:0]          cust_cycles,
  input  logic [LW-1:0]          instr_lat,
  input  logic [NDEST-1:0][LW:0] dest_lat,
  input  logic [NDEST-1:0]       dest_vld,
  input  logic                   ooo_retire,
  output logic                   issue_ok,
  output logic                   stall_active,
  output logic [2:0]             stall_kind,
  output logic                   replay,
  output logic [4:0]             stall_evt
);

  logic          haz_fire, hold, evaluate;
  stall_kind_e   haz_kind, kind_q;
  logic [CW-1:0] haz_cycles;
  logic [LW-1:0] earliest, wb_cnt;
  logic          new_stall;

  hsu_hazard_eval #(.CW(CW), .LW(LW), .NDEST(NDEST)) u_eval (
    .raw_hit     (raw_hit),
    .raw_unknown (raw_unknown),
    .raw_cycles  (raw_cycles),
    .res_busy    (res_busy),
    .cust_cycles (cust_cycles),
    .instr_lat   (instr_lat),
    .dest_lat    (dest_lat),
    .dest_vld    (dest_vld),
    .ooo_retire  (ooo_retire),
    .wb_cnt      (wb_cnt),
    .haz_fire    (haz_fire),
    .haz_kind    (haz_kind),
    .haz_cycles  (haz_cycles),
    .earliest    (earliest)
  );

  hsu_stall_track #(.CW(CW)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .head_valid (head_valid),
    .haz_fire   (haz_fire),
    .haz_kind   (haz_kind),
    .haz_cycles (haz_cycles),
    .hold       (hold),
    .replay     (replay),
    .evaluate   (evaluate),
    .kind_q     (kind_q)
  );

  hsu_wb_order #(.LW(LW)) u_wb (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (issue_ok),
    .ooo_retire (ooo_retire),
    .instr_lat  (instr_lat),
    .wb_cnt     (wb_cnt)
  );

  assign new_stall    = evaluate && haz_fire;
  assign issue_ok     = evaluate && !haz_fire;
  assign stall_active = hold || new_stall;
  assign stall_kind   = hold ? kind_q : (new_stall ? haz_kind : SK_NONE);
  assign stall_evt    = evt_of(stall_kind);

  AST_HOLD_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !issue_ok) else $error("AST_HOLD_NO_ISSUE");  // R8
  AST_ORDER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_ok && !ooo_retire && wb_cnt != '0) |-> (earliest >= wb_cnt)) else $error("AST_ORDER_KEPT");  // R6
  AST_RES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (new_stall && stall_kind == SK_DISPATCH) |=> replay) else $error("AST_RES_ONE");  // R4
  AST_EVT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_evt[0] == stall_evt[1]) && (stall_evt[2] == stall_evt[3])) else $error("AST_EVT_PAIR");  // R9
  AST_ISSUE_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ok |-> (!res_busy && cust_cycles == '0)) else $error("AST_ISSUE_NO_BUSY");  // R2
  AST_EVT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_active |-> (stall_evt == '0 && stall_kind == 3'd0)) else $error("AST_EVT_IDLE");  // R10

endmodule

// File: tb/test_hazard_stall_unit.sv
`timescale 1ns/1ps
module test_hazard_stall_unit;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic head_valid = 0, raw_hit = 0, raw_unknown = 0, res_busy = 0, ooo_retire = 0;
  logic [5:0] raw_cycles = 0, cust_cycles = 0, instr_lat = 0;
  logic [1:0][6:0] dest_lat = '0;
  logic [1:0] dest_vld = 0;
  logic issue_ok, stall_active, replay;
  logic [2:0] stall_kind;
  logic [4:0] stall_evt;

  int checks = 0, errors = 0, cyc = 1, wd = 0;
  int m_stalled = 0, m_rel = 0, m_kind = 0, m_wbat = 0, last_issue = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hazard_stall_unit i_hazard_stall_unit (
    .clk(clk), .rst_n(rst_n), .head_valid(head_valid), .raw_hit(raw_hit),
    .raw_unknown(raw_unknown), .raw_cycles(raw_cycles), .res_busy(res_busy),
    .cust_cycles(cust_cycles), .instr_lat(instr_lat), .dest_lat(dest_lat),
    .dest_vld(dest_vld), .ooo_retire(ooo_retire), .issue_ok(issue_ok),
    .stall_active(stall_active), .stall_kind(stall_kind), .replay(replay),
    .stall_evt(stall_evt)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, what, cyc, act, exp);
    end
  endtask

  function automatic int evt_exp(input int k);
    if (k == 1) return 3;
    if (k == 2) return 12;
    if (k == 3) return 16;
    return 0;
  endfunction

  // One modelled cycle: compare at falling edge + 1 ns, advance to next falling edge.
  task automatic step(input string tag);
    int wbv, holding, rep, evl, n, k, e, act_e, kind_e, iss_e;
    #1;
    wbv = (m_wbat > cyc) ? m_wbat - cyc : 0;
    holding = (m_stalled != 0) && (cyc < m_rel);
    rep = (m_stalled != 0) && (cyc == m_rel);
    evl = head_valid && !holding;
    e = instr_lat;
    for (int i = 0; i < 2; i++)
      if (dest_vld[i]) begin
        if ($signed(dest_lat[i]) < 0) e = 0;
        else if (int'(dest_lat[i]) < e) e = dest_lat[i];
      end
    n = 0; k = 0;
    if (raw_hit && (raw_unknown || raw_cycles != 0)) begin n = raw_unknown ? 1 : raw_cycles; k = 1; end
    else if (res_busy) begin n = 1; k = 2; end
    else if (cust_cycles != 0) begin n = cust_cycles; k = 3; end
    else if (wbv != 0 && !ooo_retire && e < wbv) begin n = wbv - e; k = 4; end
    iss_e = evl && (n == 0);
    act_e = holding || (evl && n > 0);
    kind_e = holding ? m_kind : ((evl && n > 0) ? k : 0);
    chk(tag, "issue_ok", issue_ok, iss_e);
    chk(tag, "stall_active", stall_active, act_e);
    chk(tag, "stall_kind R9", stall_kind, kind_e);
    chk(tag, "replay R8", replay, rep);
    chk(tag, "stall_evt R9", stall_evt, evt_exp(kind_e));
    if (evl && n > 0) begin m_stalled = 1; m_rel = cyc + n; m_kind = k; end
    else if (!holding) m_stalled = 0;
    if (iss_e && !ooo_retire && instr_lat != 0) m_wbat = cyc + instr_lat;
    last_issue = iss_e;
    @(negedge clk);
    cyc++;
  endtask

  task automatic idle(input string tag, input int n);
    head_valid = 0;
    for (int i = 0; i < n; i++) step(tag);
  endtask

  // Present one instruction and keep it at the head until it issues.
  task automatic issue_one(input string tag, input bit rh, input bit ru, input int rc,
                           input bit bz, input int cc, input int lat,
                           input int d0, input int d1, input bit [1:0] dv,
                           input bit ooo, input bit noise);
    for (int g = 0; g < 300; g++) begin
      if (noise && m_stalled != 0 && cyc < m_rel) begin
        head_valid = g[0]; raw_hit = 1; raw_unknown = 0; raw_cycles = 1;
        res_busy = 1; cust_cycles = 2; instr_lat = 0; dest_vld = 0; ooo_retire = 0;
      end else begin
        head_valid = 1; raw_hit = rh; raw_unknown = ru; raw_cycles = 6'(rc);
        res_busy = bz; cust_cycles = 6'(cc); instr_lat = 6'(lat);
        dest_lat[0] = 7'(d0); dest_lat[1] = 7'(d1); dest_vld = dv; ooo_retire = ooo;
      end
      step(tag);
      if (last_issue != 0) break;
      // hazards that stall only once are dropped after the first stall
      if (g == 0) begin rh = 0; bz = 0; cc = 0; end
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000 && !done) begin
        done = 1; errors++;
        $display("FAIL R8 watchdog: actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state, then a plain issue
    idle("R1", 2);
    issue_one("R1", 0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 0, 0);
    // R3: dependency lengths, unknown, zero count
    for (int c = 0; c < 9; c++) issue_one("R3", 1, 0, c, 0, 0, 0, 0, 0, 2'b00, 0, 0);
    issue_one("R3", 1, 1, 9, 0, 0, 0, 0, 0, 2'b00, 0, 0);
    issue_one("R3", 0, 0, 7, 0, 0, 0, 0, 0, 2'b00, 0, 0);
    // R4: busy resource
    for (int r = 0; r < 3; r++) issue_one("R4", 0, 0, 0, 1, 0, 0, 0, 0, 2'b00, 0, 0);
    // R5: custom lengths
    for (int c = 0; c < 7; c++) issue_one("R5", 0, 0, 0, 0, c, 0, 0, 0, 2'b00, 0, 0);
    // R2: every combination of the four hazards after a long-latency primer
    for (int m = 0; m < 16; m++) begin
      issue_one("R2", 0, 0, 0, 0, 0, 12, 0, 0, 2'b00, 1, 0);
      issue_one("R7", 0, 0, 0, 0, 0, 12, 0, 0, 2'b00, 0, 0);
      issue_one("R2", m[0], 0, 3, m[1], m[2] ? 5 : 0, 1, 0, 0, 2'b00, !m[3], 0);
    end
    // R6/R7: ordering delay over primer latency and earliest write-back
    for (int p = 0; p < 8; p++)
      for (int q = 0; q < 8; q++) begin
        issue_one("R7", 0, 0, 0, 0, 0, p, 0, 0, 2'b00, 0, 0);
        issue_one("R6", 0, 0, 0, 0, 0, 9, q, -1, {q[0] & q[1], 1'b1}, q == 5, 0);
        if (q == 3) idle("R7", 2);
      end
    // R8: inputs ignored while held; replay that stalls again
    issue_one("R8", 1, 0, 6, 0, 0, 0, 0, 0, 2'b00, 0, 1);
    issue_one("R8", 0, 0, 0, 0, 7, 0, 0, 0, 2'b00, 0, 1);
    head_valid = 1; raw_hit = 0; res_busy = 1; cust_cycles = 0; instr_lat = 0;
    dest_vld = 0; ooo_retire = 0;
    step("R8");
    res_busy = 0; cust_cycles = 3;
    step("R8");
    cust_cycles = 0;
    for (int i = 0; i < 6; i++) step("R8");
    // R10: combinational response on a fresh idle-to-hazard edge
    idle("R10", 3);
    issue_one("R10", 0, 0, 0, 0, 2, 4, 2, 1, 2'b11, 0, 0);
    idle("R1", 8);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule